// File: doc/BRIEF.md
# Slave-Mode Integration Pin Decoder

This block sits between three active-low external integration-control pins and the pixel array's timing logic. When the sensor runs under external control, the surrounding system shapes the integration period by driving these pins. The block turns each pin combination into an internal event: a pixel reset, a dual-slope partial reset, a triple-slope partial reset, or a frame-transfer start. In this mode any line-count thresholds programmed for internal timing play no part. Those thresholds, the readout sequencing and the internal line counting all belong to other blocks.

The three pins, the external-control select and the non-destructive-readout select all pass through the same two-flop synchronizer to the core clock. The combination is then decoded and registered, so every output follows its cause by a fixed three core-clock cycles. The three resets are level outputs: each stays high for as long as its combination is held. Frame transfer is a single-cycle strobe, given once each time the pins enter the all-low state. With non-destructive readout selected, the three reset outputs are held low. The pins still time the frame transfer.

Top module: `integ_pin_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycles after its release, all four outputs are low.
- R2: When `slave_en` is sampled low, no output goes high for any pin combination. Each output reflects `slave_en` three clock cycles later.
- R3: Bit 0 of `int_n` is pin 1. With slave mode on and `int_n` = 3'b110, `pix_rst` is high three cycles later. It stays high for every cycle the combination is held. It drops three cycles after pin 1 returns high, which is when integration begins.
- R4: Bit 1 of `int_n` is pin 2. With `int_n` = 3'b101 (pin 2 low alone), `ds_rst` is high three cycles later, for as long as the combination is held.
- R5: Bit 2 of `int_n` is pin 3. With `int_n` = 3'b011 (pin 3 low alone), `ts_rst` is high three cycles later, for as long as the combination is held.
- R6: Entering `int_n` = 3'b000 from any other value gives `ft_start` high for exactly one cycle, three cycles after the entry. No further strobe follows while 3'b000 is held.
- R7: After the pins leave 3'b000 for at least one cycle, a new entry into 3'b000 gives a new `ft_start` strobe.
- R8: With `ndr_en` high, `pix_rst`, `ds_rst` and `ts_rst` stay low. `ft_start` still follows R6 and R7.
- R9: The combinations 3'b111, 3'b100, 3'b010 and 3'b001 produce no output.
- R10: At most one of the four outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Selects external-pin control of integration |
| ndr_en | input | 1 | Non-destructive readout: blocks the reset outputs |
| int_n | input | 3 | Active-low integration pins; bit 0 = pin 1, bit 1 = pin 2, bit 2 = pin 3 |
| pix_rst | output | 1 | Internal pixel reset level |
| ds_rst | output | 1 | Internal dual-slope reset level |
| ts_rst | output | 1 | Internal triple-slope reset level |
| ft_start | output | 1 | One-cycle frame-transfer start strobe |

## Verification
A wrong synchronizer depth or a missing register shows up as a reset level that starts or ends one cycle off the three-cycle mark. The cycle-aligned scoreboard reports this on the first edge of the first pulse. A stuck edge-detect flag shows in one of two ways. Either the strobe is missing when the pins first enter the all-low state, or it repeats on the cycle right after. Both are visible within four cycles of that entry. A wrong decode or a wrong gating of the mode bits drives a reset output high for a combination that must stay quiet. This is caught three cycles after that combination is applied.

// File: rtl/integ_dec_pkg.sv
package integ_dec_pkg;
  localparam int PIN_W = 3;

  typedef enum logic [2:0] {
    CMB_IDLE,
    CMB_PIX,
    CMB_DS,
    CMB_TS,
    CMB_XFER,
    CMB_OTHER
  } combo_e;

  typedef struct packed {
    logic pix;
    logic ds;
    logic ts;
    logic ft;
  } integ_evt_t;

  // Active-low pins: bit0 = pin 1, bit1 = pin 2, bit2 = pin 3
  function automatic combo_e classify(input logic [PIN_W-1:0] p);
    case (p)
      3'b111:  return CMB_IDLE;
      3'b110:  return CMB_PIX;
      3'b101:  return CMB_DS;
      3'b011:  return CMB_TS;
      3'b000:  return CMB_XFER;
      default: return CMB_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/combo_classify.sv
module combo_classify
  import integ_dec_pkg::*;
(
  input  logic [PIN_W-1:0] pins,
  output combo_e           cls
);
  always_comb cls = classify(pins);
endmodule

// File: rtl/evt_register.sv
module evt_register
  import integ_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  combo_e     cls,
  input  logic       xfer_entry,
  input  logic       slave_on,
  input  logic       ndr_on,
  output integ_evt_t evt
);
  integ_evt_t nxt;
  logic       rst_ok;

  always_comb begin
    rst_ok  = slave_on && !ndr_on;
    nxt.pix = rst_ok && (cls == CMB_PIX);
    nxt.ds  = rst_ok && (cls == CMB_DS);
    nxt.ts  = rst_ok && (cls == CMB_TS);
    nxt.ft  = slave_on && xfer_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= nxt;
  end
endmodule

// File: rtl/integ_pin_decoder.sv
module integ_pin_decoder
  import integ_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_en,
  input  logic             ndr_en,
  input  logic [PIN_W-1:0] int_n,
  output logic             pix_rst,
  output logic             ds_rst,
  output logic             ts_rst,
  output logic             ft_start
);
  localparam int RAW_W = PIN_W + 2;
  localparam logic [RAW_W-1:0] RST_VEC = {2'b00, {PIN_W{1'b1}}};

  logic [RAW_W-1:0] raw_in, sync_out;
  logic [PIN_W-1:0] sync_pins;
  logic             sync_slave, sync_ndr;
  combo_e           cls;
  logic             prev_xfer, xfer_entry;
  integ_evt_t       evt;

  assign raw_in = {ndr_en, slave_en, int_n};

  for (genvar i = 0; i < RAW_W; i++) begin : g_sync
    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_VEC[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[i]), .q(sync_out[i])
    );
  end

  assign sync_pins  = sync_out[PIN_W-1:0];
  assign sync_slave = sync_out[PIN_W];
  assign sync_ndr   = sync_out[PIN_W+1];

  combo_classify u_cls (.pins(sync_pins), .cls(cls));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_xfer <= 1'b0;
    else        prev_xfer <= (cls == CMB_XFER);
  end

  assign xfer_entry = (cls == CMB_XFER) && !prev_xfer;

  evt_register u_evt (
    .clk(clk), .rst_n(rst_n), .cls(cls), .xfer_entry(xfer_entry),
    .slave_on(sync_slave), .ndr_on(sync_ndr), .evt(evt)
  );

  assign pix_rst  = evt.pix;
  assign ds_rst   = evt.ds;
  assign ts_rst   = evt.ts;
  assign ft_start = evt.ft;
endmodule

// File: rtl/integ_dec_chk.sv
module integ_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slave_en,
  input logic       ndr_en,
  input logic [2:0] int_n,
  input logic       pix_rst,
  input logic       ds_rst,
  input logic       ts_rst,
  input logic       ft_start
);
  logic [1:0] warm;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end
  assign ready = (warm == 2'd3);

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_rst, ds_rst, ts_rst, ft_start})); // R10

  AST_FT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ft_start |=> !ft_start); // R6

  AST_SLAVE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !$past(slave_en, 3)) |-> !(pix_rst || ds_rst || ts_rst || ft_start)); // R2

  AST_NDR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ndr_en, 3)) |-> !(pix_rst || ds_rst || ts_rst)); // R8

  AST_PIX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pix_rst == ($past(slave_en, 3) && !$past(ndr_en, 3) && ($past(int_n, 3) == 3'b110)))); // R3

  AST_DS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ds_rst == ($past(slave_en, 3) && !$past(ndr_en, 3) && ($past(int_n, 3) == 3'b101)))); // R4

  AST_TS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ts_rst == ($past(slave_en, 3) && !$past(ndr_en, 3) && ($past(int_n, 3) == 3'b011)))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ($past(int_n, 3) == 3'b111)) |-> !(pix_rst || ds_rst || ts_rst || ft_start)); // R9

  AST_FT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ft_start) |-> ($past(int_n, 3) == 3'b000)); // R7
endmodule

bind integ_pin_decoder integ_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ndr_en(ndr_en), .int_n(int_n),
  .pix_rst(pix_rst), .ds_rst(ds_rst), .ts_rst(ts_rst), .ft_start(ft_start)
);

// File: tb/sim_integ_pin_decoder.sv
module sim_integ_pin_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slave_en = 1'b0;
  logic       ndr_en = 1'b0;
  logic [2:0] int_n = 3'b111;
  logic       pix_rst, ds_rst, ts_rst, ft_start;

  always #10 clk = ~clk; // 50 MHz

  integ_pin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .ndr_en(ndr_en), .int_n(int_n),
    .pix_rst(pix_rst), .ds_rst(ds_rst), .ts_rst(ts_rst), .ft_start(ft_start)
  );

  typedef struct {
    int         due;
    logic [3:0] exp;   // {pix, ds, ts, ft}
    string      req;
  } item_t;

  item_t      sbq[$];
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  logic [2:0] last_pins = 3'b111;
  bit         done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Expected outputs written straight from the requirement text
  function automatic logic [3:0] expect_of(logic [2:0] p, logic [2:0] prev, logic sl, logic nd);
    logic [3:0] e;
    e = 4'b0000;
    if (sl) begin
      if (!nd && p == 3'b110) e[3] = 1'b1;
      if (!nd && p == 3'b101) e[2] = 1'b1;
      if (!nd && p == 3'b011) e[1] = 1'b1;
      if (p == 3'b000 && prev != 3'b000) e[0] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {pix,ds,ts,ft} actual=%b expected=%b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(logic [2:0] p, logic sl, logic nd, string req);
    item_t it;
    @(negedge clk);
    int_n = p; slave_en = sl; ndr_en = nd;
    it.due = cyc + 3;
    it.exp = expect_of(p, last_pins, sl, nd);
    it.req = req;
    sbq.push_back(it);
    last_pins = p;
  endtask

  task automatic hold(logic [2:0] p, logic sl, logic nd, int n, string req);
    for (int i = 0; i < n; i++) step(p, sl, nd, req);
  endtask

  // Monitor: compare each expected item in the cycle it falls due
  always @(negedge clk) begin
    logic [3:0] act;
    act = {pix_rst, ds_rst, ts_rst, ft_start};
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      check(it.req, act, it.exp);
      check("R10", {3'b000, ($countones(act) > 1)}, 4'b0000);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {pix_rst, ds_rst, ts_rst, ft_start}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {pix_rst, ds_rst, ts_rst, ft_start}, 4'b0000);

    hold(3'b111, 1, 0, 3, "R9");
    hold(3'b110, 1, 0, 4, "R3");
    hold(3'b111, 1, 0, 3, "R3");
    hold(3'b101, 1, 0, 2, "R4");
    hold(3'b111, 1, 0, 1, "R9");
    hold(3'b011, 1, 0, 3, "R5");
    hold(3'b111, 1, 0, 2, "R9");
    hold(3'b000, 1, 0, 5, "R6");
    hold(3'b111, 1, 0, 1, "R7");
    hold(3'b000, 1, 0, 2, "R7");
    hold(3'b110, 1, 0, 1, "R3");
    hold(3'b000, 1, 0, 2, "R7");
    hold(3'b100, 1, 0, 2, "R9");
    hold(3'b010, 1, 0, 2, "R9");
    hold(3'b001, 1, 0, 2, "R9");
    hold(3'b111, 1, 1, 2, "R8");
    hold(3'b110, 1, 1, 3, "R8");
    hold(3'b101, 1, 1, 2, "R8");
    hold(3'b011, 1, 1, 2, "R8");
    hold(3'b000, 1, 1, 3, "R8");
    hold(3'b111, 0, 0, 2, "R2");
    hold(3'b110, 0, 0, 2, "R2");
    hold(3'b101, 0, 0, 2, "R2");
    hold(3'b011, 0, 0, 2, "R2");
    hold(3'b000, 0, 0, 3, "R2");
    hold(3'b111, 1, 0, 2, "R9");
    hold(3'b110, 1, 0, 2, "R3");
    hold(3'b000, 1, 0, 2, "R6");
    hold(3'b111, 1, 0, 5, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule